// File: doc/BRIEF.md
# USB Root Port Status and Resume Control

This block holds the status and control bits of one root port in a USB host controller, together with a small sequencer that times resume signalling. Software reaches it through a single-word register with a write enable, write data, per-byte write strobes and a read-data bus. On the port side it watches the port power indication, the over-current flag, the sampled line state (J or K) and a suspend indication. It drives a request to put full-speed K on the port and a one-cycle port-change-detect pulse to the controller's status logic.

The over-current active bit is a registered copy of the over-current input. Any change of that copy sets a sticky change bit, which software clears by writing one. A second sticky bit records changes of the port's enabled state. The resume bit can be set by software or by hardware when the line moves from J to K during suspend. A down-counter then holds it for a fixed number of clock cycles and clears it without software help. While port power is off, the enable-change bit and the resume bit read as zero, the resume request is low, and their state is cleared.

Register layout (bit positions in `wr_data` and `rd_data`): bit 0 over-current active, bit 1 over-current change, bit 8 enable change, bit 16 resume. All other read bits are 0.

Top module: `usb_port_status_reg`

## Requirements
- R1: Bit 0 of `rd_data` is read-only and equals the value `ovc_in` had one clock earlier. Writes to bit 0 have no effect.
- R2: Bit 1 of `rd_data` becomes 1 on the clock edge at which `ovc_in` differs from the current bit 0, whether the change is a rise or a fall. It then stays 1 until cleared.
- R3: A write with `wr_data[1]`=1 and `wr_strb[0]`=1 clears bit 1. A write with `wr_data[1]`=0, or with `wr_strb[0]`=0, leaves bit 1 unchanged.
- R4: If a clearing write to bit 1 arrives on the same edge as a new over-current transition, bit 1 is 1 after that edge.
- R5: Bit 8 becomes 1 on an edge where `port_en` differs from its value one clock earlier while `pwr_on` is 1. A write with `wr_data[8]`=1 and `wr_strb[1]`=1 clears it. It reads 0 at once whenever `pwr_on` is 0, and changes of `port_en` while power is off do not set it.
- R6: A write with `wr_data[16]`=1 and `wr_strb[2]`=1 while the resume bit is 0 sets bit 16. `resume_k` equals bit 16. The bit stays 1 for exactly RESUME_CYCLES clock cycles and then clears itself. Writes of 0 to bit 16 have no effect, and a software start gives no `pcd_pulse`.
- R7: `line_k` (1 = K, 0 = J) is registered. When `suspended` is 1 and the two most recent registered samples are J then K, bit 16 and `pcd_pulse` both go to 1 on the next edge, which is two edges after `line_k` rose. `pcd_pulse` lasts one cycle, and the resume then lasts RESUME_CYCLES cycles as in R6.
- R8: A K seen while `suspended` is 0, and any K-to-K, K-to-J or J-to-J sequence, starts no resume and gives no pulse.
- R9: While `pwr_on` is 0, `resume_k` is low at once and bit 16 reads 0. A running resume is cancelled and does not continue when power returns, and a J-to-K edge during suspend gives neither a resume nor a pulse.
- R10: After reset all of `rd_data` is 0 and `resume_k` and `pcd_pulse` are 0. Bits other than 0, 1, 8 and 16 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_data | input | DATA_W | Write data |
| wr_strb | input | DATA_W/8 | Byte write strobes |
| rd_data | output | DATA_W | Register read value |
| pwr_on | input | 1 | Port power is on |
| ovc_in | input | 1 | Over-current condition present |
| port_en | input | 1 | Port enabled state |
| suspended | input | 1 | Port is in suspend |
| line_k | input | 1 | Line state, 1 = K, 0 = J |
| resume_k | output | 1 | Request to drive full-speed K on the port |
| pcd_pulse | output | 1 | One-cycle port change detect |

## Verification
The assertions assume that `ovc_in`, `port_en`, `line_k`, `suspended` and `pwr_on` are synchronous to `clk` and stable around the edge, and that RESUME_CYCLES is at least 1. The bench changes every input one nanosecond after a rising edge, with the resume length set to six cycles. It sweeps all suspend and line-sample combinations, every pairing of write data and strobe on the clearable bits, and an eight-step over-current pattern, with the expected bit values worked out step by step in the bench.

// File: rtl/usb_psr_pkg.sv
package usb_psr_pkg;
    localparam int OVC_ACT_BIT = 0;
    localparam int OVC_CHG_BIT = 1;
    localparam int EN_CHG_BIT  = 8;
    localparam int RESUME_BIT  = 16;

    typedef struct packed {
        logic act;
        logic chg;
    } ovc_state_t;

    typedef struct packed {
        logic lvl;
        logic flag;
    } chg_state_t;
endpackage

// File: rtl/psr_ovc_track.sv
module psr_ovc_track
    import usb_psr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovc_in,
    input  logic clr_req,
    output logic act,
    output logic chg
);
    ovc_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.act = ovc_in;
        if (clr_req) begin
            s_d.chg = 1'b0;
        end
        // a transition overrides a simultaneous clear
        if (ovc_in != s_q.act) begin
            s_d.chg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act = s_q.act;
    assign chg = s_q.chg;
endmodule

// File: rtl/psr_chg_flag.sv
module psr_chg_flag
    import usb_psr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic level_in,
    input  logic clr_req,
    output logic flag
);
    chg_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.lvl = level_in;
        if (clr_req) begin
            s_d.flag = 1'b0;
        end
        if (pwr_on && (level_in != s_q.lvl)) begin
            s_d.flag = 1'b1;
        end
        if (!pwr_on) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag = s_q.flag;
endmodule

// File: rtl/psr_resume_seq.sv
module psr_resume_seq #(
    parameter int RESUME_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic suspended,
    input  logic line_k,
    input  logic sw_start,
    output logic active,
    output logic pcd
);
    localparam int CNT_W = $clog2(RESUME_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RESUME_CYCLES - 1);

    typedef struct packed {
        logic             line_q;
        logic             line_prev;
        logic             active;
        logic             pcd;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       j_to_k;

    assign j_to_k = suspended && !s_q.line_prev && s_q.line_q;

    always_comb begin
        s_d           = s_q;
        s_d.line_q    = line_k;
        s_d.line_prev = s_q.line_q;
        s_d.pcd       = 1'b0;
        if (s_q.active) begin
            if (s_q.cnt == '0) begin
                s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (j_to_k || sw_start) begin
            s_d.active = 1'b1;
            s_d.cnt    = LOAD_VAL;
            s_d.pcd    = j_to_k;
        end
        if (!pwr_on) begin
            s_d.active = 1'b0;
            s_d.cnt    = '0;
            s_d.pcd    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;
    assign pcd    = s_q.pcd;
endmodule

// File: rtl/usb_port_status_reg.sv
module usb_port_status_reg
    import usb_psr_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int RESUME_CYCLES = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_strb,
    output logic [DATA_W-1:0]     rd_data,
    input  logic                  pwr_on,
    input  logic                  ovc_in,
    input  logic                  port_en,
    input  logic                  suspended,
    input  logic                  line_k,
    output logic                  resume_k,
    output logic                  pcd_pulse
);
    logic ovc_clr, en_clr, res_set;
    logic ovc_act, ovc_chg, en_chg, res_act;
    logic wr_unused;

    assign ovc_clr = wr_en && wr_strb[OVC_CHG_BIT/8] && wr_data[OVC_CHG_BIT];
    assign en_clr  = wr_en && wr_strb[EN_CHG_BIT/8]  && wr_data[EN_CHG_BIT];
    assign res_set = wr_en && wr_strb[RESUME_BIT/8]  && wr_data[RESUME_BIT];
    assign wr_unused = ^{wr_data, wr_strb};

    psr_ovc_track u_ovc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovc_in  (ovc_in),
        .clr_req (ovc_clr),
        .act     (ovc_act),
        .chg     (ovc_chg)
    );

    psr_chg_flag u_en_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .level_in (port_en),
        .clr_req  (en_clr),
        .flag     (en_chg)
    );

    psr_resume_seq #(
        .RESUME_CYCLES (RESUME_CYCLES)
    ) u_resume (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_on    (pwr_on),
        .suspended (suspended),
        .line_k    (line_k),
        .sw_start  (res_set),
        .active    (res_act),
        .pcd       (pcd_pulse)
    );

    always_comb begin
        rd_data              = '0;
        rd_data[OVC_ACT_BIT] = ovc_act;
        rd_data[OVC_CHG_BIT] = ovc_chg;
        rd_data[EN_CHG_BIT]  = en_chg && pwr_on;
        rd_data[RESUME_BIT]  = res_act && pwr_on;
    end

    assign resume_k = res_act && pwr_on;
endmodule

// File: rtl/usb_port_status_chk.sv
module usb_port_status_chk
    import usb_psr_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int RESUME_CYCLES = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovc_in,
    input logic              pwr_on,
    input logic [DATA_W-1:0] rd_data,
    input logic              resume_k,
    input logic              pcd_pulse
);
    localparam int RUN_W = $clog2(RESUME_CYCLES + 2);

    logic             started_q;
    logic [RUN_W-1:0] run_q;
    logic             rd_unused;

    assign rd_unused = ^rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            run_q     <= '0;
        end else begin
            started_q <= 1'b1;
            if (!resume_k) begin
                run_q <= '0;
            end else if (run_q <= RUN_W'(RESUME_CYCLES)) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1
    ovc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> rd_data[OVC_ACT_BIT] == $past(ovc_in));

    // R2
    ovc_change_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && ($past(ovc_in) != $past(rd_data[OVC_ACT_BIT]))) |-> rd_data[OVC_CHG_BIT]);

    // R9
    power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (!resume_k && !rd_data[RESUME_BIT] && !rd_data[EN_CHG_BIT] && !pcd_pulse));

    // R7
    pcd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcd_pulse |=> !pcd_pulse);

    // R7
    pcd_with_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcd_pulse |-> resume_k);

    // R6
    resume_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RESUME_CYCLES));
endmodule

bind usb_port_status_reg usb_port_status_chk #(
    .DATA_W        (DATA_W),
    .RESUME_CYCLES (RESUME_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovc_in    (ovc_in),
    .pwr_on    (pwr_on),
    .rd_data   (rd_data),
    .resume_k  (resume_k),
    .pcd_pulse (pcd_pulse)
);

// File: tb/usb_port_status_reg_tb.sv
`timescale 1ns/1ps
module usb_port_status_reg_tb;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] rd_data;
    logic        pwr_on = 1'b1;
    logic        ovc_in = 1'b0;
    logic        port_en = 1'b0;
    logic        suspended = 1'b0;
    logic        line_k = 1'b0;
    logic        resume_k;
    logic        pcd_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_port_status_reg #(.DATA_W(32), .RESUME_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_data(rd_data), .pwr_on(pwr_on),
        .ovc_in(ovc_in), .port_en(port_en), .suspended(suspended),
        .line_k(line_k), .resume_k(resume_k), .pcd_pulse(pcd_pulse)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] s);
        wr_en = 1'b1;
        wr_data = d;
        wr_strb = s;
        tick();
        wr_en = 1'b0;
        wr_data = '0;
        wr_strb = '0;
    endtask

    task automatic measure_resume(input int already, input string tag);
        int n = already;
        int seen_pcd = 0;
        for (int k = 0; k < 100 && resume_k; k++) begin
            if (k == 1) wr(32'h0, 4'hF);
            else tick();
            if (pcd_pulse) seen_pcd++;
            if (resume_k) n++;
        end
        check({tag, " length"}, n, N);
        check({tag, " no extra pulse"}, seen_pcd, 0);
        check({tag, " bit16 cleared"}, rd_data[16], 1'b0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic act_m;
        logic chg_m;
        logic [7:0] pat;
        logic [31:0] w;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        check("R10 rd_data", rd_data, 32'h0);
        check("R10 resume_k", resume_k, 1'b0);
        check("R10 pcd", pcd_pulse, 1'b0);

        // R1 / R2 over-current sweep
        act_m = 1'b0;
        chg_m = 1'b0;
        pat = 8'b1011_0010;
        for (int i = 0; i < 8; i++) begin
            ovc_in = pat[i];
            tick();
            if (pat[i] != act_m) chg_m = 1'b1;
            act_m = pat[i];
            check("R1 ovc active", rd_data[0], act_m);
            check("R2 ovc change", rd_data[1], chg_m);
        end
        wr(32'h1, 4'h1);
        check("R1 write ignored", rd_data[0], act_m);

        // R3 all data/strobe pairings
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                ovc_in = ~ovc_in;
                tick();
                check("R3 preset", rd_data[1], 1'b1);
                w = '0;
                w[1] = d[0];
                wr(w, {3'b000, s[0]});
                check("R3 w1c", rd_data[1], (d == 1 && s == 1) ? 1'b0 : 1'b1);
            end
        end

        // R4 set wins over clear
        ovc_in = ~ovc_in;
        wr(32'h2, 4'h1);
        check("R4 collision", rd_data[1], 1'b1);
        check("R4 active", rd_data[0], ovc_in);
        wr(32'h2, 4'h1);
        check("R3 clear after collision", rd_data[1], 1'b0);

        // R5 enable change
        port_en = 1'b1;
        tick();
        check("R5 set", rd_data[8], 1'b1);
        wr(32'h100, 4'b0010);
        check("R5 w1c", rd_data[8], 1'b0);
        port_en = 1'b0;
        tick();
        check("R5 set on fall", rd_data[8], 1'b1);
        wr(32'h100, 4'b1101);
        check("R5 strobe off", rd_data[8], 1'b1);
        wr(32'h100, 4'b0010);
        check("R5 clear", rd_data[8], 1'b0);
        port_en = 1'b1;
        tick();
        pwr_on = 1'b0;
        #1;
        check("R5 gated by power", rd_data[8], 1'b0);
        tick();
        port_en = 1'b0;
        tick();
        pwr_on = 1'b1;
        #1;
        check("R5 cleared while off", rd_data[8], 1'b0);
        tick();
        check("R5 no set from off change", rd_data[8], 1'b0);

        // R6 software resume
        wr(32'h1_0000, 4'b0100);
        check("R6 started", resume_k, 1'b1);
        check("R6 bit16", rd_data[16], 1'b1);
        check("R6 no pcd", pcd_pulse, 1'b0);
        measure_resume(1, "R6");

        // R7 J-to-K in suspend
        suspended = 1'b1;
        line_k = 1'b0;
        repeat (3) tick();
        line_k = 1'b1;
        tick();
        check("R7 not yet", resume_k, 1'b0);
        tick();
        check("R7 pcd", pcd_pulse, 1'b1);
        check("R7 resume", resume_k, 1'b1);
        check("R7 bit16", rd_data[16], 1'b1);
        tick();
        check("R7 pcd single", pcd_pulse, 1'b0);
        check("R7 still resuming", resume_k, 1'b1);
        measure_resume(2, "R7");
        suspended = 1'b0;
        line_k = 1'b0;

        // R8 / R7 sweep over suspend and line pairs
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 2; a++) begin
                for (int b = 0; b < 2; b++) begin
                    logic exp_r;
                    suspended = 1'b0;
                    line_k = a[0];
                    repeat (3) tick();
                    suspended = s[0];
                    line_k = b[0];
                    tick();
                    tick();
                    exp_r = s[0] && !a[0] && b[0];
                    check(exp_r ? "R7 sweep resume" : "R8 sweep resume", resume_k, exp_r);
                    check(exp_r ? "R7 sweep pcd" : "R8 sweep pcd", pcd_pulse, exp_r);
                    suspended = 1'b0;
                    repeat (N + 2) tick();
                    check("R8 sweep idle", resume_k, 1'b0);
                end
            end
        end
        line_k = 1'b0;

        // R9 power gating of resume
        wr(32'h1_0000, 4'b0100);
        tick();
        tick();
        pwr_on = 1'b0;
        #1;
        check("R9 resume_k off", resume_k, 1'b0);
        check("R9 bit16 off", rd_data[16], 1'b0);
        tick();
        pwr_on = 1'b1;
        #1;
        check("R9 no continue", resume_k, 1'b0);
        tick();
        check("R9 stays idle", resume_k, 1'b0);
        pwr_on = 1'b0;
        suspended = 1'b1;
        repeat (3) tick();
        line_k = 1'b1;
        tick();
        tick();
        check("R9 no pcd while off", pcd_pulse, 1'b0);
        pwr_on = 1'b1;
        #1;
        check("R9 no resume while off", resume_k, 1'b0);
        suspended = 1'b0;
        tick();
        check("R10 unused bits", rd_data & ~32'h0001_0103, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule